// File: doc/BRIEF.md
# Four-Channel Ignition Driver Selector with Mode-Dependent Fault Flag

This block holds the digital control for a four-channel spark driver stage. A two-bit select and an enable choose which single channel is driven high; all other channels are driven low. A separate active-low hold input forces every channel into a high-impedance state. That state is latched: it is left only after the hold input is high and the low select bit then shows a low-to-high transition. The channel outputs are given as an output-enable vector and a drive-level vector, so the pad logic outside can build the three-state drivers.

The block also produces one active-low fault flag. Each channel has a comparator bit from the analog side that reads 1 when the channel pin is above the fault threshold. Which comparator pattern counts as a fault depends on the operating mode. In high-impedance mode any high pin is a fault (an open load or a short to battery; the two look the same). With enable low any high pin is a fault (short to battery). With enable high only a low pin on the driven channel is a fault (short to ground). The flag is blanked for a programmable number of clocks after any change of the output state, so that switching transients are not reported.

The hold, enable and select inputs each pass through a two-flop synchronizer. The release edge is detected on the synchronized low select bit.

Top module: `ign_chan_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released until a release sequence occurs, `oe` is 0 on every channel, `drv` is 0, and `fault_n` is 1 until the blanking window has run out.
- R2: When `hold_n` is sampled low at a clock edge, `oe` is 0 on all channels after the third rising edge counted from that edge, whatever the other inputs are.
- R3: The high-impedance state stays latched after `hold_n` returns high. It is released only when the synchronized `sel_in[0]` goes from 0 to 1 while the synchronized `hold_n` is 1. A `sel_in[0]` that is already high, or that rose while `hold_n` was low, does not release it.
- R4: Out of high-impedance mode, with `en_in` low, `oe` is all ones and `drv` is all zeros.
- R5: Out of high-impedance mode, with `en_in` high, `drv` is one-hot with bit index equal to `sel_in` (0 selects channel 0, 1 selects channel 1, 2 selects channel 2, 3 selects channel 3). It tracks the select continuously.
- R6: At most one bit of `drv` is high at any time, and `drv` is non-zero only when `oe` is all ones.
- R7: In high-impedance mode, any set bit of `above_thr` is a fault condition.
- R8: Out of high-impedance mode with `en_in` low, any set bit of `above_thr` is a fault condition.
- R9: Out of high-impedance mode with `en_in` high, a fault condition exists only when the `above_thr` bit of the selected channel is 0; the bits of the other channels have no effect.
- R10: `fault_n` goes to 0 at a clock edge only when the fault condition holds there and the `{oe,drv}` state has been unchanged for the last `BLANK`+1 edges. It is registered, and is 1 on the edge after any change of `{oe,drv}`.
- R11: A change on `hold_n`, `en_in` or `sel_in` reaches `oe`/`drv` no sooner than two rising edges later (three for the release of the latch).

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| hold_n | input | 1 | Active-low hold; low forces and latches high-impedance mode |
| en_in | input | 1 | Enable for the selected channel |
| sel_in | input | 2 | Channel select; bit 0 also serves as the release strobe |
| above_thr | input | 4 | Per-channel comparator: 1 = pin above fault threshold |
| oe | output | 4 | Per-channel output enable (0 = high impedance) |
| drv | output | 4 | Per-channel drive level while enabled |
| fault_n | output | 1 | Active-low fault flag |

## Verification
The assertions assume that the control inputs change only between clock edges and that the comparator bits are already stable logic levels when sampled; the release property also assumes that the power-on reset is held for at least four clocks so the input history it looks back on is defined. The stimulus drives every input on the falling clock edge, keeps reset low for several clocks, and mixes directed sequences (hold entry, the blocked and the valid release, select sweeps, fast select toggling inside the blanking window) with a stretch of random enable, select, comparator and hold values.

// File: rtl/ign_pkg.sv
// Shared types for the ignition channel selector.
package ign_pkg;
    // Operating mode that decides both the drive pattern and the fault rule.
    typedef enum logic [1:0] {
        MODE_HIZ   = 2'd0,
        MODE_IDLE  = 2'd1,
        MODE_DRIVE = 2'd2
    } ign_mode_e;
endpackage

// File: rtl/ign_sync.sv
// Two-flop synchronizer for a vector of asynchronous control inputs.
// Assumes each bit is an independent level; no bus coherency is implied.
// RST_VAL sets each bit's value during reset so that no false edge follows reset.
module ign_sync #(
    parameter int              W       = 4,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] meta_q;

    // Purpose: two register stages to settle metastable inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q_sync <= RST_VAL;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end
endmodule

// File: rtl/ign_ctrl.sv
// Output state control: holds the latched high-impedance flag, detects the
// release edge on select bit 0, and decodes the select into a one-hot drive.
// Assumes all inputs are already synchronized to clk.
module ign_ctrl
    import ign_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int SELW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold_s,
    input  logic            en_s,
    input  logic [SELW-1:0] sel_s,
    output ign_mode_e       mode,
    output logic [NCH-1:0]  oe,
    output logic [NCH-1:0]  drv
);
    logic hiz_q;
    logic rel_prev_q;
    logic rel_rise;

    assign rel_rise = sel_s[0] & ~rel_prev_q;

    // Purpose: latch high impedance on hold, clear it on a release edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hiz_q      <= 1'b1;
            rel_prev_q <= 1'b1;
        end else begin
            rel_prev_q <= sel_s[0];
            if (!hold_s) begin
                hiz_q <= 1'b1;
            end else if (hiz_q && rel_rise) begin
                hiz_q <= 1'b0;
            end
        end
    end

    // Purpose: derive the operating mode from the latch and the enable.
    always_comb begin
        if (hiz_q) begin
            mode = MODE_HIZ;
        end else if (en_s) begin
            mode = MODE_DRIVE;
        end else begin
            mode = MODE_IDLE;
        end
    end

    assign oe = {NCH{~hiz_q}};

    // One comparator per channel for the one-hot drive decode.
    for (genvar i = 0; i < NCH; i++) begin : g_drv
        assign drv[i] = (mode == MODE_DRIVE) && (sel_s == SELW'(i));
    end
endmodule

// File: rtl/ign_fault.sv
// Fault flag generation: picks the fault rule for the current mode and
// blanks the result for BLANK+1 edges after any change of the output state.
// Assumes above_thr is a stable level at each rising edge.
module ign_fault
    import ign_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int BLANK = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  ign_mode_e      mode,
    input  logic [NCH-1:0] oe,
    input  logic [NCH-1:0] drv,
    input  logic [NCH-1:0] above_thr,
    output logic           fault_n
);
    localparam int CW = $clog2(BLANK + 2);

    logic [2*NCH-1:0] state_q;
    logic [2*NCH-1:0] state_now;
    logic [CW-1:0]    blank_cnt;
    logic             changed;
    logic             raw_fault;

    assign state_now = {oe, drv};
    assign changed   = (state_now != state_q);

    // Purpose: choose the comparator rule for the active diagnostic mode.
    always_comb begin
        if (mode == MODE_DRIVE) begin
            raw_fault = |(drv & ~above_thr);
        end else begin
            raw_fault = |above_thr;
        end
    end

    // Purpose: track output changes, run the blanking count, register the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= '0;
            blank_cnt <= CW'(BLANK);
            fault_n   <= 1'b1;
        end else begin
            state_q <= state_now;
            if (changed) begin
                blank_cnt <= CW'(BLANK);
            end else if (blank_cnt != '0) begin
                blank_cnt <= blank_cnt - 1'b1;
            end
            fault_n <= ~(raw_fault && !changed && (blank_cnt == '0));
        end
    end
endmodule

// File: rtl/ign_chan_ctrl.sv
// Top of the ignition channel selector. Synchronizes the control inputs,
// runs the output state control, and produces the blanked fault flag.
// Assumes the analog side turns oe/drv into three-state pins and supplies
// one above-threshold comparator bit per channel.
module ign_chan_ctrl
    import ign_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int BLANK = 4,
    localparam int SELW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold_n,
    input  logic            en_in,
    input  logic [SELW-1:0] sel_in,
    input  logic [NCH-1:0]  above_thr,
    output logic [NCH-1:0]  oe,
    output logic [NCH-1:0]  drv,
    output logic            fault_n
);
    localparam int               SW       = SELW + 2;
    localparam logic [SW-1:0]    SYNC_RST = SW'(1);

    logic [SW-1:0]   sync_q;
    logic            hold_s;
    logic            en_s;
    logic [SELW-1:0] sel_s;
    ign_mode_e       mode;

    ign_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({hold_n, en_in, sel_in}),
        .q_sync  (sync_q)
    );

    assign {hold_s, en_s, sel_s} = sync_q;

    ign_ctrl #(.NCH(NCH), .SELW(SELW)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold_s (hold_s),
        .en_s   (en_s),
        .sel_s  (sel_s),
        .mode   (mode),
        .oe     (oe),
        .drv    (drv)
    );

    ign_fault #(.NCH(NCH), .BLANK(BLANK)) u_fault (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .oe        (oe),
        .drv       (drv),
        .above_thr (above_thr),
        .fault_n   (fault_n)
    );
endmodule

// File: rtl/ign_chk.sv
// Property checker for ign_chan_ctrl, attached through bind.
// Assumes inputs change only between rising edges.
module ign_chk #(
    parameter int NCH  = 4,
    parameter int SELW = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            hold_n,
    input logic            en_in,
    input logic [SELW-1:0] sel_in,
    input logic [NCH-1:0]  above_thr,
    input logic [NCH-1:0]  oe,
    input logic [NCH-1:0]  drv,
    input logic            fault_n
);
    // R6: never more than one driven channel
    a_r6_onehot_drive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(drv));

    // R6: a driven channel implies all outputs enabled
    a_r6_drive_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (drv != '0) |-> (oe == {NCH{1'b1}}));

    // R1: output enables move together
    a_r1_oe_uniform: assert property (@(posedge clk) disable iff (!rst_n)
        (oe == '0) || (oe == {NCH{1'b1}}));

    // R2: a sampled low hold reaches the enables three edges later
    a_r2_hold_forces_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(hold_n, 3) |-> (oe == '0));

    // R3: leaving high impedance follows a low-to-high step on select bit 0
    a_r3_release_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe[0]) |-> ($past(sel_in[0], 3) && !$past(sel_in[0], 4) && $past(hold_n, 3)));

    // R10: no fault on the edge after an output state change
    a_r10_blank_after_change: assert property (@(posedge clk) disable iff (!rst_n)
        ({oe, drv} != $past({oe, drv})) |=> fault_n);
endmodule

bind ign_chan_ctrl ign_chk #(.NCH(NCH), .SELW(SELW)) u_chk (.*);

// File: tb/ign_chan_ctrl_tb.sv
module ign_chan_ctrl_tb;
    localparam int NCH   = 4;
    localparam int BLANK = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hold_n = 1'b1;
    logic       en_in = 1'b0;
    logic [1:0] sel_in = 2'b00;
    logic [3:0] above_thr = 4'b0000;
    logic [3:0] oe;
    logic [3:0] drv;
    logic       fault_n;

    int    n_checks = 0;
    int    n_errors = 0;
    string req = "R1";
    bit    done = 1'b0;

    always #10 clk = ~clk;

    ign_chan_ctrl #(.NCH(NCH), .BLANK(BLANK)) u_dut (
        .clk(clk), .rst_n(rst_n), .hold_n(hold_n), .en_in(en_in),
        .sel_in(sel_in), .above_thr(above_thr),
        .oe(oe), .drv(drv), .fault_n(fault_n)
    );

    // Behavioural reference: input pipeline history plus mode rules.
    logic [3:0] h_hold = 4'b0000;   // history of sampled hold_n, bit 0 newest
    logic [3:0] h_en   = 4'b0000;
    logic [1:0] p_sel1 = 2'b01;     // two newest samples of sel_in
    logic [1:0] p_sel2 = 2'b00;
    bit         m_hiz = 1'b1;
    bit         m_d0_last = 1'b1;
    logic [7:0] m_prev = 8'h00;
    int         m_run = 0;
    bit         m_fault_n = 1'b1;

    function automatic logic [3:0] exp_oe();
        return m_hiz ? 4'b0000 : 4'b1111;
    endfunction

    function automatic logic [3:0] exp_drv();
        if (m_hiz || !h_en[1]) return 4'b0000;
        return 4'b0001 << p_sel2;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            h_hold = 4'b0000; h_en = 4'b0000;
            p_sel1 = 2'b01; p_sel2 = 2'b00;
            m_hiz = 1'b1; m_d0_last = 1'b1;
            m_prev = 8'h00; m_run = 0; m_fault_n = 1'b1;
        end else begin
            logic [7:0] now;
            bit raw;
            bit hold_s;
            now = {exp_oe(), exp_drv()};
            if (now != m_prev) m_run = 0;
            else if (m_run < 1000) m_run++;
            if (exp_drv() != 4'b0000) raw = |(exp_drv() & ~above_thr);
            else raw = |above_thr;
            m_fault_n = !(raw && (m_run >= BLANK + 1));
            m_prev = now;
            hold_s = h_hold[1];
            if (!hold_s) m_hiz = 1'b1;
            else if (m_hiz && p_sel2[0] && !m_d0_last) m_hiz = 1'b0;
            m_d0_last = p_sel2[0];
            p_sel2 = p_sel1;
            p_sel1 = sel_in;
            h_hold = {h_hold[2:0], hold_n};
            h_en   = {h_en[2:0], en_in};
        end
    end

    task automatic check(string r, string what, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", r, what, act, exp, $time);
        end
    endtask

    // Compare against the reference on every falling edge.
    always @(negedge clk) begin
        if (!done) begin
            check(req, "oe", {4'h0, oe}, {4'h0, exp_oe()});
            check(req, "drv", {4'h0, drv}, {4'h0, exp_drv()});
            check(req, "fault_n", {7'h0, fault_n}, {7'h0, m_fault_n});
            check("R6", "drv count", 8'($countones(drv) <= 1), 8'd1);
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        // R1: reset state, select bit 0 already high
        req = "R1";
        rst_n = 1'b0; hold_n = 1'b1; en_in = 1'b0; sel_in = 2'b01; above_thr = 4'h0;
        step(5);
        rst_n = 1'b1;
        step(3);
        // R3: a select bit 0 high since reset does not release
        req = "R3";
        step(8);
        // R7: open load / battery short seen in high impedance
        req = "R7";
        above_thr = 4'b0100;
        step(10);
        above_thr = 4'b0000;
        step(4);
        // R11: release sequence and its latency
        req = "R11";
        sel_in = 2'b00;
        step(3);
        sel_in = 2'b01;
        step(4);
        // R4: released with enable low
        req = "R4";
        step(6);
        // R8: battery short while enable low
        req = "R8";
        above_thr = 4'b1000;
        step(9);
        above_thr = 4'b0000;
        step(4);
        // R5: sweep every select code with healthy loads
        req = "R5";
        en_in = 1'b1;
        above_thr = 4'hF;
        for (int s = 0; s < 4; s++) begin
            sel_in = 2'(s);
            step(8);
        end
        // R9: selected channel low is a fault, others ignored
        req = "R9";
        sel_in = 2'd2;
        step(8);
        above_thr = 4'b1011;
        step(9);
        above_thr = 4'b0100;
        step(9);
        // R10: select toggled faster than the blanking window
        req = "R10";
        above_thr = 4'b0000;
        for (int k = 0; k < 8; k++) begin
            sel_in = 2'(k);
            step(3);
        end
        step(9);
        // R2: hold low with enable high forces high impedance
        req = "R2";
        above_thr = 4'hF;
        sel_in = 2'd1;
        hold_n = 1'b0;
        step(6);
        // R3: select bit 0 rose during hold; no release after hold returns
        req = "R3";
        sel_in = 2'd0;
        step(3);
        sel_in = 2'd1;
        step(3);
        hold_n = 1'b1;
        step(8);
        sel_in = 2'd0;
        step(3);
        sel_in = 2'd3;
        step(8);
        // R6: random mix of all inputs
        req = "R6";
        for (int i = 0; i < 400; i++) begin
            en_in     = 1'($urandom);
            sel_in    = 2'($urandom);
            above_thr = 4'($urandom);
            hold_n    = ($urandom % 16) != 0;
            step(1 + ($urandom % 3));
        end
        hold_n = 1'b1;
        step(6);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule